// File: doc/BRIEF.md
# Frame-Swapped Double-Bank Receive Buffer

This block buffers the receive data of a periodic streaming endpoint. It holds two banks of equal size. The serial-side logic writes packet bytes into one bank, the write bank. The processor drains the other bank, the read bank, one byte per read strobe. A count output reports how many valid bytes the read bank holds.

A frame-start pulse ends each frame. On that pulse the write bank is frozen and becomes the new read bank, and the old read bank becomes the next write bank, emptied. No handshake is needed from the processor for this exchange. Bytes that were not read before the pulse are lost for good.

Writes that exceed one bank in a single frame are discarded and raise a sticky overflow flag. A clear input returns the whole buffer to its empty state at any time. Packet decoding, CRC and frame-token detection sit upstream and reach this block as single-cycle strobes.

Top module: `frame_swap_rx_fifo`

## Requirements
- R1: After reset, rx_count_o is 0, ovf_o is 0 and rd_data_o is 0.
- R2: Bytes written during a frame do not change rx_count_o or the readable data until the next frame-start pulse. rx_count_o changes only on frame-start or clear.
- R3: One cycle after a frame-start pulse, rx_count_o equals the number of bytes accepted in the frame that ended. A write accepted in the same cycle as the pulse counts toward that ending frame.
- R4: rd_data_o shows the byte at the read position of the read bank, starting with the first byte written in that frame. Each rd_en_i strobe advances to the next byte, in write order.
- R5: Once the read position reaches rx_count_o, rd_data_o is 0, and further rd_en_i strobes do not move the read position.
- R6: A frame-start pulse discards any unread bytes of the read bank. Reading then restarts at the first byte of the newly frozen bank.
- R7: A bank holds at most PKT_BYTES (64) bytes per frame. Write strobes beyond that in the same frame are dropped, and ovf_o goes to 1 one cycle after the first dropped write. Exactly PKT_BYTES writes do not set ovf_o.
- R8: ovf_o stays 1 across frame-start pulses until a clear or a reset.
- R9: clr_i takes priority over a frame-start pulse and a write in the same cycle. One cycle after clr_i, rx_count_o is 0, ovf_o is 0, rd_data_o is 0 and the write bank is empty, so that the next frame-start pulse with no writes gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of both banks, counts and flag |
| sof_i | input | 1 | Single-cycle frame-start pulse that swaps the banks |
| wr_en_i | input | 1 | Serial-side write strobe |
| wr_data_i | input | DATA_W (8) | Byte to store in the write bank |
| rd_en_i | input | 1 | Processor read strobe, consumes one byte |
| rd_data_o | output | DATA_W (8) | Byte at the read position, 0 when none remain |
| rx_count_o | output | CNT_W (7) | Number of bytes in the read bank |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that sof_i and clr_i are single-cycle pulses sampled on the same edge as the data strobes. They also assume that a read strobe in the same cycle as a frame-start pulse is overridden by the swap. The stimulus drives every strobe on the falling edge for exactly one cycle. It reads only between frame-start pulses, except in the deliberate tests of a write coinciding with a pulse and of a clear coinciding with a pulse. Fill levels from empty to one full bank and past it are swept, and every expected byte is computed from its frame number and position.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   typedef enum logic {
      BANK0 = 1'b0,
      BANK1 = 1'b1
   } bank_sel_t;

   function automatic bank_sel_t other_bank(input bank_sel_t b);
      return (b == BANK0) ? BANK1 : BANK0;
   endfunction
endpackage

// File: rtl/rxb_bank_store.sv
module rxb_bank_store
   import rxb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PKT_BYTES = 64,
   localparam int ADDR_W   = $clog2(PKT_BYTES)
) (
   input  logic              clk,
   input  logic              we,
   input  bank_sel_t         w_bank,
   input  logic [ADDR_W-1:0] w_addr,
   input  logic [DATA_W-1:0] w_data,
   input  bank_sel_t         r_bank,
   input  logic [ADDR_W-1:0] r_addr,
   output logic [DATA_W-1:0] r_data
);
   logic [DATA_W-1:0] bank_word [2];

   for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam bank_sel_t ID = (b == 0) ? BANK0 : BANK1;
      logic [DATA_W-1:0] mem [PKT_BYTES];

      always_ff @(posedge clk) begin
         if (we && (w_bank == ID)) begin
            mem[w_addr] <= w_data;
         end
      end

      assign bank_word[b] = mem[r_addr];
   end

   assign r_data = (r_bank == BANK1) ? bank_word[1] : bank_word[0];
endmodule

// File: rtl/rxb_wr_ctrl.sv
module rxb_wr_ctrl
   import rxb_pkg::*;
#(
   parameter int PKT_BYTES = 64,
   localparam int ADDR_W   = $clog2(PKT_BYTES),
   localparam int CNT_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sof,
   input  logic              wr_en,
   output logic              wr_accept,
   output logic [ADDR_W-1:0] wr_addr,
   output bank_sel_t         wr_bank,
   output logic [CNT_W-1:0]  wr_level,
   output logic [CNT_W-1:0]  frozen_cnt,
   output logic              ovf
);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(PKT_BYTES);

   logic full;

   assign full       = (wr_level == FULL_LVL);
   assign wr_accept  = wr_en & ~full & ~clr;
   assign wr_addr    = wr_level[ADDR_W-1:0];
   assign frozen_cnt = wr_level + CNT_W'(wr_accept);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_level <= '0;
         wr_bank  <= BANK0;
         ovf      <= 1'b0;
      end else if (clr) begin
         wr_level <= '0;
         wr_bank  <= BANK0;
         ovf      <= 1'b0;
      end else begin
         if (wr_en && full) begin
            ovf <= 1'b1;
         end
         if (sof) begin
            wr_bank  <= other_bank(wr_bank);
            wr_level <= '0;
         end else if (wr_accept) begin
            wr_level <= wr_level + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxb_rd_ctrl.sv
module rxb_rd_ctrl #(
   parameter int DATA_W    = 8,
   parameter int PKT_BYTES = 64,
   localparam int ADDR_W   = $clog2(PKT_BYTES),
   localparam int CNT_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sof,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  frozen_cnt,
   input  logic [DATA_W-1:0] bank_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_ptr,
   output logic [CNT_W-1:0]  vis_cnt,
   output logic [DATA_W-1:0] rd_data
);
   logic avail;

   assign avail   = (rd_ptr < vis_cnt);
   assign rd_addr = rd_ptr[ADDR_W-1:0];
   assign rd_data = avail ? bank_word : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis_cnt <= '0;
         rd_ptr  <= '0;
      end else if (clr) begin
         vis_cnt <= '0;
         rd_ptr  <= '0;
      end else if (sof) begin
         vis_cnt <= frozen_cnt;
         rd_ptr  <= '0;
      end else if (rd_en && avail) begin
         rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/frame_swap_rx_fifo.sv
module frame_swap_rx_fifo
   import rxb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PKT_BYTES = 64,
   localparam int ADDR_W   = $clog2(PKT_BYTES),
   localparam int CNT_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              sof_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]  rx_count_o,
   output logic              ovf_o
);
   initial begin
      if (DATA_W < 1) $fatal(1, "DATA_W must be at least 1");
      if (PKT_BYTES < 2 || (PKT_BYTES & (PKT_BYTES - 1)) != 0)
         $fatal(1, "PKT_BYTES must be a power of two of at least 2");
   end

   logic              wr_accept;
   logic [ADDR_W-1:0] wr_addr;
   bank_sel_t         wr_bank;
   logic [CNT_W-1:0]  wr_level;
   logic [CNT_W-1:0]  frozen_cnt;
   logic [ADDR_W-1:0] rd_addr;
   logic [CNT_W-1:0]  rd_ptr;
   logic [DATA_W-1:0] bank_word;

   rxb_wr_ctrl #(.PKT_BYTES(PKT_BYTES)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_i),
      .sof       (sof_i),
      .wr_en     (wr_en_i),
      .wr_accept (wr_accept),
      .wr_addr   (wr_addr),
      .wr_bank   (wr_bank),
      .wr_level  (wr_level),
      .frozen_cnt(frozen_cnt),
      .ovf       (ovf_o)
   );

   rxb_bank_store #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_store (
      .clk   (clk),
      .we    (wr_accept),
      .w_bank(wr_bank),
      .w_addr(wr_addr),
      .w_data(wr_data_i),
      .r_bank(other_bank(wr_bank)),
      .r_addr(rd_addr),
      .r_data(bank_word)
   );

   rxb_rd_ctrl #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_i),
      .sof       (sof_i),
      .rd_en     (rd_en_i),
      .frozen_cnt(frozen_cnt),
      .bank_word (bank_word),
      .rd_addr   (rd_addr),
      .rd_ptr    (rd_ptr),
      .vis_cnt   (rx_count_o),
      .rd_data   (rd_data_o)
   );
endmodule

// File: rtl/frame_swap_rx_fifo_chk.sv
module frame_swap_rx_fifo_chk #(
   parameter int PKT_BYTES = 64,
   localparam int CNT_W    = $clog2(PKT_BYTES) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_i,
   input logic             sof_i,
   input logic             wr_en_i,
   input logic             rd_en_i,
   input logic [CNT_W-1:0] rx_count_o,
   input logic             ovf_o,
   input logic [CNT_W-1:0] wr_level,
   input logic [CNT_W-1:0] rd_ptr
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(PKT_BYTES);

   // R9
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (rx_count_o == '0) && !ovf_o && (wr_level == '0));

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_i) |=> ovf_o);

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_i && !clr_i) |=> $stable(rx_count_o));

   // R3
   sof_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !clr_i && !wr_en_i) |=> (rx_count_o == $past(wr_level)));

   // R7
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_level <= LIM) && (rx_count_o <= LIM));

   // R4
   rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !sof_i && !clr_i && (rd_ptr < rx_count_o))
      |=> (rd_ptr == $past(rd_ptr) + 1'b1));

   // R5
   rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_i && !clr_i && (rd_ptr >= rx_count_o)) |=> $stable(rd_ptr));

   // R6
   sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_i && !clr_i) |=> (rd_ptr == '0));
endmodule

bind frame_swap_rx_fifo frame_swap_rx_fifo_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .sof_i     (sof_i),
   .wr_en_i   (wr_en_i),
   .rd_en_i   (rd_en_i),
   .rx_count_o(rx_count_o),
   .ovf_o     (ovf_o),
   .wr_level  (wr_level),
   .rd_ptr    (rd_ptr)
);

// File: tb/frame_swap_rx_fifo_tb.sv
module frame_swap_rx_fifo_tb;
   localparam int PKT = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0;
   logic       sof_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       rd_en_i = 1'b0;
   logic [7:0] rd_data_o;
   logic [6:0] rx_count_o;
   logic       ovf_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   frame_swap_rx_fifo u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .sof_i     (sof_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_en_i),
      .rd_data_o (rd_data_o),
      .rx_count_o(rx_count_o),
      .ovf_o     (ovf_o)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] pat(input int f, input int i);
      return 8'((f * 37 + i * 11 + 5) & 255);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic w, input logic [7:0] d, input logic s,
                      input logic r, input logic c);
      wr_en_i = w; wr_data_i = d; sof_i = s; rd_en_i = r; clr_i = c;
      @(negedge clk);
      wr_en_i = 0; sof_i = 0; rd_en_i = 0; clr_i = 0;
   endtask

   task automatic fill(input int f, input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, pat(f, i), 1'b0, 1'b0, 1'b0);
   endtask

   task automatic drain(input string tag, input int f, input int n);
      for (int i = 0; i < n; i++) begin
         chk(tag, int'(rd_data_o), int'(pat(f, i)));
         cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      end
   endtask

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", int'(rx_count_o), 0);
      chk("R1 ovf", int'(ovf_o), 0);
      chk("R1 data", int'(rd_data_o), 0);

      // sweep of every fill level 0..PKT
      prev = 0;
      for (int n = 0; n <= PKT; n++) begin
         fill(n, n);
         chk("R2 count before sof", int'(rx_count_o), prev);
         cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
         chk("R3 count after sof", int'(rx_count_o), n);
         drain("R4 data", n, n);
         for (int k = 0; k < 2; k++) begin
            chk("R5 past end data", int'(rd_data_o), 0);
            cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
         end
         chk("R5 count held", int'(rx_count_o), n);
         prev = n;
      end
      chk("R7 no ovf at exact fill", int'(ovf_o), 0);

      // R6 unread bytes dropped at swap
      fill(100, 5);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      drain("R6 partial read", 100, 2);
      fill(101, 3);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk("R6 count", int'(rx_count_o), 3);
      drain("R6 new bank data", 101, 3);
      chk("R6 end", int'(rd_data_o), 0);

      // R3 write coincident with sof joins the ending frame
      fill(102, 4);
      cyc(1'b1, pat(102, 4), 1'b1, 1'b0, 1'b0);
      chk("R3 coincident count", int'(rx_count_o), 5);
      drain("R3 coincident data", 102, 5);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk("R3 empty frame count", int'(rx_count_o), 0);

      // R7 overflow
      fill(103, PKT + 6);
      chk("R7 ovf set", int'(ovf_o), 1);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk("R7 saturated count", int'(rx_count_o), PKT);
      drain("R7 kept data", 103, PKT);
      chk("R7 end", int'(rd_data_o), 0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk("R8 ovf after sof", int'(ovf_o), 1);
      chk("R8 count", int'(rx_count_o), 0);

      // R9 clear beats sof and write
      fill(104, 6);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      fill(105, 3);
      chk("R9 pre count", int'(rx_count_o), 6);
      cyc(1'b1, 8'hAA, 1'b1, 1'b0, 1'b1);
      chk("R9 count", int'(rx_count_o), 0);
      chk("R9 ovf", int'(ovf_o), 0);
      chk("R9 data", int'(rd_data_o), 0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk("R9 write bank empty", int'(rx_count_o), 0);
      fill(106, 2);
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk("R9 resume count", int'(rx_count_o), 2);
      drain("R9 resume data", 106, 2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule